// File: doc/BRIEF.md
# Latched BCD to Seven-Segment LCD Decoder

This block turns a four-bit binary-coded decimal digit into the seven segment lines of a liquid crystal display digit. A level-controlled input latch either passes the incoming digit straight through to the decoder or holds the digit it last captured. The decoder produces the familiar segment shapes for 0 to 9, including the tailed forms of 6 and 9. Codes 10 to 15 give a dark digit.

A blanking input turns every segment off whatever digit is present. A phase input inverts all seven outputs. When the same square wave drives the phase input and the display backplane, each lit segment sees an AC voltage and each unlit segment sees none.

The latch is a clocked register that loads on every clock edge where the latch-enable is high. While the latch-enable is high, a combinational bypass presents the live input in the same cycle, so the outputs track the inputs without delay.

Top module: `bcd_lcd_decoder`

## Requirements
- R1: While latch_en_i is high, seg_o reflects the current bcd_i in the same cycle, with no clock edge needed (bcd_i[0] is the least significant bit).
- R2: While latch_en_i is low, seg_o reflects the code that bcd_i carried at the last rising clock edge where latch_en_i was high. Changes on bcd_i have no effect.
- R3: When blank_i is high and phase_i is low, seg_o is 7'b0000000 whatever bcd_i and latch_en_i are.
- R4: A code of 10 to 15 gives seg_o = 7'b0000000 with phase_i low.
- R5: With phase_i high, each bit of seg_o is the inverse of its value with phase_i low. This includes the blank state, which becomes 7'b1111111.
- R6: seg_o[6] is segment a and seg_o[0] is segment g (1 = lit). With phase_i low, digits 0 to 5 give 1111110, 0110000, 1101101, 1111001, 0110011 and 1011011.
- R7: With phase_i low, digits 6 to 9 give 1011111, 1110000, 1111111 and 1111011.
- R8: A synchronous active-high rst clears the held code to 0, so after reset with latch_en_i low and phase_i low, seg_o is 7'b1111110.
- R9: An illegal code captured in the latch keeps the digit dark for as long as latch_en_i stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the input latch register |
| rst | input | 1 | Synchronous active-high reset; clears the held code to 0 |
| bcd_i | input | 4 | BCD digit, bit 0 least significant |
| latch_en_i | input | 1 | High: latch transparent; low: hold the captured code |
| blank_i | input | 1 | High: all segments off |
| phase_i | input | 1 | High: invert every segment output |
| seg_o | output | 7 | Segment drive, bit 6 = a down to bit 0 = g |

## Verification
The assertions assume that every input is at a known 0 or 1 at each rising clock edge once reset has been released. They also assume that reset is applied before the first edge they consider. The bench holds rst high from time zero for several cycles and changes inputs only on the falling edge. It reads the combinational outputs a nanosecond later, so each value is settled and well away from the edge that loads the latch. The hold checks change bcd_i only after the capturing edge has passed with latch_en_i high.

// File: rtl/seg_lcd_pkg.sv
package seg_lcd_pkg;
    localparam int BCD_W = 4;
    localparam int SEG_N = 7;
    localparam int MAX_DIGIT = 9;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_N-1:0] seg_t;

    typedef struct packed {
        bcd_t code;
        logic blank;
    } dec_in_t;

    // Bit 6 = segment a, bit 0 = segment g
    function automatic seg_t digit_shape(input bcd_t d);
        seg_t s;
        case (d)
            4'd0: s = 7'b1111110;
            4'd1: s = 7'b0110000;
            4'd2: s = 7'b1101101;
            4'd3: s = 7'b1111001;
            4'd4: s = 7'b0110011;
            4'd5: s = 7'b1011011;
            4'd6: s = 7'b1011111;
            4'd7: s = 7'b1110000;
            4'd8: s = 7'b1111111;
            4'd9: s = 7'b1111011;
            default: s = '0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/bcd_hold_latch.sv
module bcd_hold_latch
    import seg_lcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bcd_t bcd_i,
    input  logic load_i,
    output bcd_t code_o
);
    bcd_t held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (load_i)
            held_q <= bcd_i;
    end

    // Transparent bypass while loading
    always_comb code_o = load_i ? bcd_i : held_q;

    // R2
    held_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(held_q));
    // R2
    held_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> held_q == $past(bcd_i));
    // R8
    held_reset_chk: assert property (@(posedge clk)
        rst |=> held_q == '0);
endmodule

// File: rtl/bcd_seg_decode.sv
module bcd_seg_decode
    import seg_lcd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  dec_in_t dec_i,
    output seg_t    raw_o
);
    logic legal;

    always_comb begin
        legal = (dec_i.code <= bcd_t'(MAX_DIGIT));
        if (dec_i.blank || !legal)
            raw_o = '0;
        else
            raw_o = digit_shape(dec_i.code);
    end

    // R3
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        dec_i.blank |-> raw_o == '0);
    // R4
    illegal_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_i.code > bcd_t'(MAX_DIGIT)) |-> raw_o == '0);
    // R6
    digit_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec_i.blank && dec_i.code <= bcd_t'(MAX_DIGIT)) |-> raw_o != '0);
endmodule

// File: rtl/seg_phase_drive.sv
module seg_phase_drive
    import seg_lcd_pkg::*;
(
    input  seg_t raw_i,
    input  logic phase_i,
    output seg_t seg_o
);
    for (genvar i = 0; i < SEG_N; i++) begin : g_seg
        assign seg_o[i] = raw_i[i] ^ phase_i;
    end
endmodule

// File: rtl/bcd_lcd_decoder.sv
module bcd_lcd_decoder
    import seg_lcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bcd_i,
    input  logic       latch_en_i,
    input  logic       blank_i,
    input  logic       phase_i,
    output logic [6:0] seg_o
);
    bcd_t    code;
    dec_in_t dec;
    seg_t    raw;

    bcd_hold_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .bcd_i  (bcd_i),
        .load_i (latch_en_i),
        .code_o (code)
    );

    always_comb begin
        dec.code  = code;
        dec.blank = blank_i;
    end

    bcd_seg_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .dec_i (dec),
        .raw_o (raw)
    );

    seg_phase_drive u_phase (
        .raw_i   (raw),
        .phase_i (phase_i),
        .seg_o   (seg_o)
    );

    // R5
    phase_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_i && phase_i) |-> seg_o == 7'b1111111);
    // R1
    follow_chk: assert property (@(posedge clk) disable iff (rst)
        (latch_en_i && !blank_i && !phase_i && bcd_i == 4'd8) |-> seg_o == 7'b1111111);
endmodule

// File: tb/bcd_lcd_decoder_tb_top.sv
module bcd_lcd_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bcd_i = '0;
    logic       latch_en_i = 1'b0;
    logic       blank_i = 1'b0;
    logic       phase_i = 1'b0;
    logic [6:0] seg_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_lcd_decoder dut_i (
        .clk(clk), .rst(rst), .bcd_i(bcd_i), .latch_en_i(latch_en_i),
        .blank_i(blank_i), .phase_i(phase_i), .seg_o(seg_o)
    );

    function automatic logic [6:0] model(input logic [3:0] d, input logic bl, input logic ph);
        logic [6:0] s;
        case (d)
            4'd0: s = 7'b1111110; 4'd1: s = 7'b0110000;
            4'd2: s = 7'b1101101; 4'd3: s = 7'b1111001;
            4'd4: s = 7'b0110011; 4'd5: s = 7'b1011011;
            4'd6: s = 7'b1011111; 4'd7: s = 7'b1110000;
            4'd8: s = 7'b1111111; 4'd9: s = 7'b1111011;
            default: s = 7'b0000000;
        endcase
        if (bl) s = 7'b0000000;
        return s ^ {7{ph}};
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        checks++;
        if (seg_o !== exp) begin
            fails++;
            $display("FAIL %s: seg_o=%b expected=%b", req, seg_o, exp);
        end
    endtask

    task automatic drive(input logic [3:0] d, input logic le, input logic bl, input logic ph);
        @(negedge clk);
        bcd_i = d; latch_en_i = le; blank_i = bl; phase_i = ph;
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(4'd6, 1'b1, 1'b0, 1'b0);
        drive(4'd6, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8 reset clears held code", 7'b1111110);
    endtask

    task automatic t_sweep();
        for (int bl = 0; bl < 2; bl++)
            for (int ph = 0; ph < 2; ph++)
                for (int d = 0; d < 16; d++) begin
                    drive(4'(d), 1'b1, 1'(bl), 1'(ph));
                    if (bl == 1) check(ph ? "R5 inverted blank" : "R3 blank", model(4'(d), 1'b1, 1'(ph)));
                    else if (d > 9) check(ph ? "R5 inverted illegal" : "R4 illegal code", model(4'(d), 1'b0, 1'(ph)));
                    else if (d > 5) check(ph ? "R5 inverted digit" : "R7 digit 6-9", model(4'(d), 1'b0, 1'(ph)));
                    else check(ph ? "R5 inverted digit" : "R6 digit 0-5", model(4'(d), 1'b0, 1'(ph)));
                end
    endtask

    task automatic t_follow();
        drive(4'd2, 1'b1, 1'b0, 1'b0);
        check("R1 transparent digit 2", model(4'd2, 1'b0, 1'b0));
        @(negedge clk); bcd_i = 4'd4; #1;
        check("R1 transparent mid-cycle change", model(4'd4, 1'b0, 1'b0));
    endtask

    task automatic t_hold();
        drive(4'd7, 1'b1, 1'b0, 1'b0);
        drive(4'd3, 1'b0, 1'b0, 1'b0);
        check("R2 hold ignores new input", model(4'd7, 1'b0, 1'b0));
        for (int d = 0; d < 16; d++) begin
            drive(4'(d), 1'b0, 1'b0, 1'b0);
            check("R2 hold across input changes", model(4'd7, 1'b0, 1'b0));
        end
        drive(4'd1, 1'b0, 1'b0, 1'b1);
        check("R2 R5 held digit inverted", model(4'd7, 1'b0, 1'b1));
        drive(4'd1, 1'b0, 1'b1, 1'b0);
        check("R3 blank over held digit", 7'b0000000);
        drive(4'd9, 1'b1, 1'b0, 1'b0);
        drive(4'd0, 1'b0, 1'b0, 1'b0);
        check("R2 recapture digit 9", model(4'd9, 1'b0, 1'b0));
    endtask

    task automatic t_illegal_hold();
        drive(4'd12, 1'b1, 1'b0, 1'b0);
        drive(4'd5, 1'b0, 1'b0, 1'b0);
        check("R9 held illegal stays dark", 7'b0000000);
        repeat (3) drive(4'd8, 1'b0, 1'b0, 1'b0);
        check("R9 held illegal after cycles", 7'b0000000);
        drive(4'd8, 1'b0, 1'b0, 1'b1);
        check("R9 R5 held illegal inverted", 7'b1111111);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_follow();
        t_hold();
        t_illegal_hold();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule